// File: doc/BRIEF.md
# Top-of-Space Register Window Claim Decoder

This block sits beside the internal-bus interface and decides whether that interface should claim the transaction in the current address phase. The claim covers the 8 KB register-and-reserved window at the very top of the 4 GB space.

The bus carries two kinds of address phase:
- **Short phase:** a single 32-bit cycle.
- **Long phase:** two cycles on the same 32-bit lines, with the low word first and the high word second. A flag marks a long phase in its first cycle.

A long-phase address claims the window only when its high word is zero. If the decoder matched the low word alone, it would also claim 64-bit addresses that belong to another agent, and two units would then answer the same phase.

The claim is registered. It appears one clock after the final address cycle and stays up for as long as the transaction strobe stays high. While the claim is up, the block presents the offset into the window. An external input reports that some other unit is claiming. If that input and the local claim are both high in the same cycle, the block sets a sticky conflict flag. Software clears the flag by writing 1.

Top module: `topwin_claim`

## Requirements
- R1: After reset, `claim`, `conflict` and `reg_off` are all 0.
- R2: A short phase (`dac`=0) whose address lies in FFFF_E000h..FFFF_FFFFh raises `claim` in the cycle after the address cycle.
- R3: A short phase whose address lies below FFFF_E000h (for example FFFF_DFFFh) never raises `claim`.
- R4: A long phase (`dac`=1 in its first cycle) puts the low word on `ad` in cycle 1 and the high word in cycle 2. `claim` stays low after cycle 1. `claim` rises after cycle 2 only if the low word is in the window and the high word is zero.
- R5: A long phase whose high word is nonzero never raises `claim`, whatever its low word.
- R6: `claim` stays high while `txn_vld` stays high. It falls one cycle after the first cycle in which `txn_vld` is sampled low. A new phase starts only after `txn_vld` has been low for at least one cycle.
- R7: While `claim` is high, `reg_off` equals address bits [12:0] of the claimed phase. While `claim` is low, `reg_off` is 0.
- R8: `conflict` becomes 1 in the cycle after a cycle in which `claim` and `other_clm` are both high. It then stays 1. `other_clm` alone never sets it.
- R9: `cfl_clr`=1 clears `conflict` in the next cycle. If a set condition occurs in the same cycle as the clear, the set wins.
- R10: If `txn_vld` falls during the high-word cycle of a long phase, the phase is abandoned and no claim is made.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_vld | input | 1 | Transaction strobe, high from the first address cycle to the end of the transaction |
| dac | input | 1 | Marks a two-cycle 64-bit address phase (sampled in the first cycle) |
| ad | input | 32 | Address word: low word, then high word for long phases |
| other_clm | input | 1 | Another unit is claiming the current transaction |
| cfl_clr | input | 1 | Write-1 clear of the conflict flag |
| claim | output | 1 | Registered claim of the register window |
| reg_off | output | 13 | Byte offset inside the window while claimed |
| conflict | output | 1 | Sticky double-claim indication |

## Verification
Two functions can fall in the same cycle:
- **Setting and clearing the sticky conflict flag.** The bench holds a window claim and drives `other_clm` and `cfl_clr` high on the same edge. It then expects `conflict` to read 1 afterwards, because the set wins.
- **The long-phase qualification and the end of the strobe.** The bench drops `txn_vld` exactly in the high-word cycle. It then expects no claim even though the low word hits the window.

In both cases the bench samples the result one edge after the stimulus.

// File: rtl/topwin_claim.sv
module topwin_claim #(
  parameter int AW    = 32,
  parameter int OFF_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             txn_vld,
  input  logic             dac,
  input  logic [AW-1:0]    ad,
  input  logic             other_clm,
  input  logic             cfl_clr,
  output logic             claim,
  output logic [OFF_W-1:0] reg_off,
  output logic             conflict
);
  localparam logic [1:0] S_IDLE = 2'd0;
  localparam logic [1:0] S_HI   = 2'd1;
  localparam logic [1:0] S_ACT  = 2'd2;

  logic [1:0]       st;
  logic             lo_hit;
  logic [OFF_W-1:0] off_q;

  wire win = &ad[AW-1:OFF_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      claim  <= 1'b0;
      lo_hit <= 1'b0;
      off_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (txn_vld) begin
          off_q <= ad[OFF_W-1:0];
          if (dac) begin
            lo_hit <= win;
            st     <= S_HI;
          end else begin
            claim <= win;
            st    <= S_ACT;
          end
        end
        S_HI: if (!txn_vld) begin
          st <= S_IDLE;
        end else begin
          claim <= lo_hit && (ad == '0);
          st    <= S_ACT;
        end
        S_ACT: if (!txn_vld) begin
          claim <= 1'b0;
          st    <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  conflict <= 1'b0;
    else if (claim && other_clm) conflict <= 1'b1;
    else if (cfl_clr)            conflict <= 1'b0;
  end

  assign reg_off = claim ? off_q : '0;
endmodule

// File: rtl/topwin_claim_chk.sv
module topwin_claim_chk #(
  parameter int AW    = 32,
  parameter int OFF_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             txn_vld,
  input logic [AW-1:0]    ad,
  input logic             other_clm,
  input logic             cfl_clr,
  input logic             claim,
  input logic [OFF_W-1:0] reg_off,
  input logic             conflict,
  input logic [1:0]       st
);
  // R6
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!txn_vld && st == 2'd2) |=> !claim);

  // R6
  rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(claim) |-> $past(txn_vld));

  // R7
  off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !claim |-> reg_off == '0);

  // R5
  hi_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && txn_vld && ad != '0) |=> !claim);

  // R10
  abandon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && !txn_vld) |=> !claim);

  // R8
  cfl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && other_clm) |=> conflict);

  // R8
  cfl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict && !cfl_clr) |=> conflict);

  // R9
  cfl_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfl_clr && !(claim && other_clm)) |=> !conflict);
endmodule

bind topwin_claim topwin_claim_chk #(.AW(AW), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .txn_vld(txn_vld), .ad(ad),
  .other_clm(other_clm), .cfl_clr(cfl_clr), .claim(claim),
  .reg_off(reg_off), .conflict(conflict), .st(st)
);

// File: tb/sim_topwin_claim.sv
module sim_topwin_claim;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        txn_vld = 1'b0;
  logic        dac = 1'b0;
  logic [31:0] ad = '0;
  logic        other_clm = 1'b0;
  logic        cfl_clr = 1'b0;
  logic        claim;
  logic [12:0] reg_off;
  logic        conflict;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  topwin_claim u0 (
    .clk(clk), .rst_n(rst_n), .txn_vld(txn_vld), .dac(dac), .ad(ad),
    .other_clm(other_clm), .cfl_clr(cfl_clr), .claim(claim),
    .reg_off(reg_off), .conflict(conflict)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_gap();
    txn_vld = 1'b0; dac = 1'b0; ad = '0;
    @(negedge clk);
    chk("R6 drop", {31'd0, claim}, 32'd0);
    @(negedge clk);
  endtask

  task automatic sac(input string req, input logic [31:0] a, input logic exp);
    txn_vld = 1'b1; dac = 1'b0; ad = a;
    @(negedge clk);
    ad = 32'h1234_5678;
    chk(req, {31'd0, claim}, {31'd0, exp});
    chk("R7 offset", {19'd0, reg_off}, exp ? {19'd0, a[12:0]} : 32'd0);
    @(negedge clk);
    chk("R6 hold", {31'd0, claim}, {31'd0, exp});
    idle_gap();
  endtask

  task automatic dacp(input string req, input logic [31:0] lo, input logic [31:0] hi,
                      input logic exp);
    txn_vld = 1'b1; dac = 1'b1; ad = lo;
    @(negedge clk);
    dac = 1'b0; ad = hi;
    chk("R4 first cycle", {31'd0, claim}, 32'd0);
    @(negedge clk);
    ad = 32'hDEAD_BEEF;
    chk(req, {31'd0, claim}, {31'd0, exp});
    chk("R7 offset", {19'd0, reg_off}, exp ? {19'd0, lo[12:0]} : 32'd0);
    @(negedge clk);
    idle_gap();
  endtask

  task automatic dac_abandon();
    txn_vld = 1'b1; dac = 1'b1; ad = 32'hFFFF_F004;
    @(negedge clk);
    txn_vld = 1'b0; dac = 1'b0; ad = '0;
    @(negedge clk);
    chk("R10 abandon", {31'd0, claim}, 32'd0);
    @(negedge clk);
    chk("R10 abandon later", {31'd0, claim}, 32'd0);
  endtask

  task automatic conflict_seq();
    other_clm = 1'b1;
    @(negedge clk);
    other_clm = 1'b0;
    chk("R8 no claim no set", {31'd0, conflict}, 32'd0);
    txn_vld = 1'b1; dac = 1'b0; ad = 32'hFFFF_E100;
    @(negedge clk);
    other_clm = 1'b1;
    @(negedge clk);
    other_clm = 1'b0;
    chk("R8 set", {31'd0, conflict}, 32'd1);
    @(negedge clk);
    chk("R8 sticky", {31'd0, conflict}, 32'd1);
    cfl_clr = 1'b1;
    @(negedge clk);
    cfl_clr = 1'b0;
    chk("R9 clear", {31'd0, conflict}, 32'd0);
    other_clm = 1'b1; cfl_clr = 1'b1;
    @(negedge clk);
    other_clm = 1'b0; cfl_clr = 1'b0;
    chk("R9 set wins", {31'd0, conflict}, 32'd1);
    idle_gap();
    chk("R8 sticky idle", {31'd0, conflict}, 32'd1);
    cfl_clr = 1'b1;
    @(negedge clk);
    cfl_clr = 1'b0;
    chk("R9 clear idle", {31'd0, conflict}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 claim", {31'd0, claim}, 32'd0);
    chk("R1 conflict", {31'd0, conflict}, 32'd0);
    chk("R1 offset", {19'd0, reg_off}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    sac("R2 low edge", 32'hFFFF_E000, 1'b1);
    sac("R2 top edge", 32'hFFFF_FFFF, 1'b1);
    sac("R2 mid", 32'hFFFF_F0A4, 1'b1);
    sac("R3 below", 32'hFFFF_DFFF, 1'b0);
    sac("R3 far", 32'h0000_E000, 1'b0);
    dacp("R4 zero high low edge", 32'hFFFF_E000, 32'h0, 1'b1);
    dacp("R4 zero high top", 32'hFFFF_FFFF, 32'h0, 1'b1);
    dacp("R4 zero high below", 32'hFFFF_DFFF, 32'h0, 1'b0);
    dacp("R5 high set top", 32'hFFFF_FFFF, 32'h0000_0001, 1'b0);
    dacp("R5 high set low edge", 32'hFFFF_E000, 32'h8000_0000, 1'b0);
    dacp("R5 high set below", 32'hFFFF_DFFF, 32'hFFFF_FFFF, 1'b0);
    dac_abandon();
    sac("R10 recover", 32'hFFFF_E010, 1'b1);
    conflict_seq();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule